// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold Controller

This block sits between a transmit data FIFO that the host fills and the MAC transmitter that empties it. It decides when the MAC may begin draining the frame at the head of the FIFO. In cut-through operation the frame is released once the FIFO holds enough 32-bit words. That word count comes from one of two four-entry tables: a 2-bit code picks the entry, and a speed flag picks the table. In store-and-forward operation the threshold is bypassed, and a frame is released only once its end-of-frame word is buffered.

When a frame starts, the block raises a one-cycle start strobe and latches the threshold then in force. It keeps that threshold until the MAC pops the end-of-frame word. Only one frame is in flight at a time. If the FIFO runs empty while a frame is draining, a sticky underrun flag is raised and held until reset.

Top module: `tx_start_gate`

## Requirements
- R1: After reset `start_pulse`, `drain_active` and `underrun` are 0, and `cur_thr` reads 32, which is the entry for code 00 in the fast table.
- R2: With `slow_mode`=0 and `store_fwd`=0, codes 00, 01, 10 and 11 give thresholds of 32, 64, 128 and 256 words. An idle block starts a frame at the clock edge where `fifo_level` is at least the threshold.
- R3: With `slow_mode`=1 and `store_fwd`=0, codes 00, 01, 10 and 11 give thresholds of 18, 24, 32 and 40 words, and frames start under the same rule as R2.
- R4: With `store_fwd`=0 and `eof_buffered`=0, a level one word below the threshold never starts a frame.
- R5: With `store_fwd`=1 the threshold has no effect. A frame starts only when `eof_buffered`=1 and `fifo_level` is nonzero.
- R6: In cut-through mode, a frame whose end-of-frame word is already buffered (`eof_buffered`=1) starts even when the level is below the threshold.
- R7: `start_pulse` is high for exactly one cycle, in the first cycle that `drain_active` is high. No further pulse occurs while a frame is draining.
- R8: A frame ends when `word_pop` and `word_pop_last` are both 1 at a clock edge. `drain_active` is 0 after that edge.
- R9: `cur_thr` takes the threshold in force at the starting edge and does not change while `drain_active` is high, whatever happens to `thr_code`, `slow_mode` or `store_fwd`.
- R10: If `fifo_level` is 0 at an edge where a frame is draining, `underrun` is 1 after that edge and stays 1 until reset, across later frames.
- R11: An idle block with `fifo_level`=0 never starts a frame, even when `eof_buffered`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_level | input | LVL_W | Words currently held in the transmit FIFO |
| eof_buffered | input | 1 | The end-of-frame word of the head frame is in the FIFO |
| word_pop | input | 1 | The MAC takes one word this cycle |
| word_pop_last | input | 1 | The word taken carries the end-of-frame mark |
| thr_code | input | 2 | Threshold table index |
| slow_mode | input | 1 | 1 selects the 10 Mb/s table, 0 selects the 100 Mb/s table |
| store_fwd | input | 1 | 1 waits for a whole frame, 0 uses the threshold |
| start_pulse | output | 1 | One-cycle strobe marking the start of a frame |
| drain_active | output | 1 | A frame is being drained |
| underrun | output | 1 | Sticky: the FIFO ran empty in the middle of a frame |
| cur_thr | output | 9 | Threshold latched at the last frame start |

## Verification
The bench sweeps every code of both tables at one word below the threshold and then exactly at it. A comparator that was off by one, or a table entry that was wrong or swapped, would start a frame early or late. It raises the threshold code in the middle of a frame to expose a design that reads its configuration live instead of latching it. It also drives a level far above every threshold while in store-and-forward mode, which catches a design that lets the threshold leak through. The empty-FIFO cases cover both states. Idle with zero words and an end-of-frame present must stay quiet. An active frame that starves must raise an underrun that survives the next frame, and a non-sticky or missing flag would lose it.

// File: rtl/txthr_pkg.sv
package txthr_pkg;
  localparam int THR_W = 9;
  localparam int CODE_W = 2;

  typedef logic [THR_W-1:0] thr_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_DRAIN = 1'b1} gate_st_e;

  function automatic thr_t thr_words(input logic [CODE_W-1:0] code, input logic slow);
    thr_t w;
    if (slow) begin
      case (code)
        2'd0:    w = thr_t'(18);
        2'd1:    w = thr_t'(24);
        2'd2:    w = thr_t'(32);
        default: w = thr_t'(40);
      endcase
    end else begin
      w = thr_t'(32) << code;
    end
    return w;
  endfunction
endpackage

// File: rtl/txthr_lookup.sv
module txthr_lookup
  import txthr_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              slow,
  output thr_t              thr
);
  always_comb begin
    thr = thr_words(code, slow);
  end
endmodule

// File: rtl/txthr_start_ctrl.sv
module txthr_start_ctrl
  import txthr_pkg::*;
#(
  parameter int LVL_W = 10
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             eof_buffered,
  input  logic             word_pop,
  input  logic             word_pop_last,
  input  logic             store_fwd,
  input  thr_t             thr_now,
  output logic             start_pulse,
  output logic             drain_active,
  output thr_t             cur_thr
);
  localparam logic [LVL_W-1:0] LVL_ZERO = '0;

  gate_st_e st_q, st_d;
  logic     start_q, start_d;
  thr_t     thr_q, thr_d;
  logic     level_ok, go, frame_end;

  always_comb begin
    level_ok  = (fifo_level >= LVL_W'(thr_now)) && !store_fwd;
    go        = (st_q == ST_IDLE) && (fifo_level != LVL_ZERO) && (eof_buffered || level_ok);
    frame_end = (st_q == ST_DRAIN) && word_pop && word_pop_last;
    st_d      = st_q;
    thr_d     = thr_q;
    start_d   = 1'b0;
    if (go) begin
      st_d    = ST_DRAIN;
      thr_d   = thr_now;
      start_d = 1'b1;
    end else if (frame_end) begin
      st_d    = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      thr_q   <= thr_words(2'b00, 1'b0);
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      if (go) begin
        thr_q <= thr_d;
      end
    end
  end

  assign start_pulse  = start_q;
  assign drain_active = (st_q == ST_DRAIN);
  assign cur_thr      = thr_q;

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  p_pulse_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> drain_active);
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && !(word_pop && word_pop_last)) |=> !start_pulse);
  p_end_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && word_pop && word_pop_last) |=> !drain_active);
  p_thr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && !start_pulse) |-> $stable(cur_thr));
  p_sf_needs_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_active && store_fwd && !eof_buffered) |=> !start_pulse);
  p_empty_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_active && fifo_level == LVL_ZERO) |=> !start_pulse);
endmodule

// File: rtl/txthr_underrun.sv
module txthr_underrun #(
  parameter int LVL_W = 10
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drain_active,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             underrun
);
  logic ur_q, ur_d, starved;

  always_comb begin
    starved = drain_active && (fifo_level == '0);
    ur_d    = ur_q | starved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ur_q <= 1'b0;
    end else if (starved) begin
      ur_q <= ur_d;
    end
  end

  assign underrun = ur_q;

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  p_set_on_starve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && fifo_level == '0) |=> underrun);
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
  import txthr_pkg::*;
#(
  parameter int LVL_W = 10
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             eof_buffered,
  input  logic             word_pop,
  input  logic             word_pop_last,
  input  logic [1:0]       thr_code,
  input  logic             slow_mode,
  input  logic             store_fwd,
  output logic             start_pulse,
  output logic             drain_active,
  output logic             underrun,
  output logic [8:0]       cur_thr
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  thr_t       thr_now;
  thr_t       thr_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  txthr_lookup u_lookup (
    .code (thr_code),
    .slow (slow_mode),
    .thr  (thr_now)
  );

  txthr_start_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .fifo_level    (fifo_level),
    .eof_buffered  (eof_buffered),
    .word_pop      (word_pop),
    .word_pop_last (word_pop_last),
    .store_fwd     (store_fwd),
    .thr_now       (thr_now),
    .start_pulse   (start_pulse),
    .drain_active  (drain_active),
    .cur_thr       (thr_held)
  );

  txthr_underrun #(.LVL_W(LVL_W)) u_ur (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .drain_active (drain_active),
    .fifo_level   (fifo_level),
    .underrun     (underrun)
  );

  assign cur_thr = thr_held;
endmodule

// File: tb/tx_start_gate_bench.sv
module tx_start_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] fifo_level = '0;
  logic       eof_buffered = 1'b0;
  logic       word_pop = 1'b0;
  logic       word_pop_last = 1'b0;
  logic [1:0] thr_code = 2'b00;
  logic       slow_mode = 1'b0;
  logic       store_fwd = 1'b0;
  logic       start_pulse, drain_active, underrun;
  logic [8:0] cur_thr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tx_start_gate u_tx_start_gate (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .eof_buffered(eof_buffered),
    .word_pop(word_pop), .word_pop_last(word_pop_last), .thr_code(thr_code),
    .slow_mode(slow_mode), .store_fwd(store_fwd), .start_pulse(start_pulse),
    .drain_active(drain_active), .underrun(underrun), .cur_thr(cur_thr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic end_frame();
    @(negedge clk);
    fifo_level = 10'd1; word_pop = 1'b1; word_pop_last = 1'b1; eof_buffered = 1'b0;
    tick();
    chk("R8 drain_active after last pop", drain_active, 0);
    @(negedge clk);
    fifo_level = '0; word_pop = 1'b0; word_pop_last = 1'b0;
    tick();
  endtask

  task automatic scan_table(input logic slow, input int t0, input int t1, input int t2, input int t3);
    int tbl[4];
    tbl = '{t0, t1, t2, t3};
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      slow_mode = slow; store_fwd = 1'b0; thr_code = 2'(c);
      fifo_level = 10'(tbl[c] - 1);
      tick();
      chk(slow ? "R4 slow below thr start" : "R4 fast below thr start", start_pulse, 0);
      @(negedge clk);
      fifo_level = 10'(tbl[c]);
      tick();
      chk(slow ? "R3 slow start at thr" : "R2 fast start at thr", start_pulse, 1);
      chk(slow ? "R3 slow cur_thr" : "R2 fast cur_thr", cur_thr, tbl[c]);
      chk("R7 active with pulse", drain_active, 1);
      tick();
      chk("R7 pulse one cycle", start_pulse, 0);
      chk("R7 still draining", drain_active, 1);
      end_frame();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 start_pulse", start_pulse, 0);
    chk("R1 drain_active", drain_active, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 cur_thr", cur_thr, 32);
  endtask

  task automatic t_store_fwd();
    @(negedge clk);
    store_fwd = 1'b1; slow_mode = 1'b0; thr_code = 2'b00; fifo_level = 10'd300;
    tick();
    tick();
    chk("R5 no start without eof", start_pulse | drain_active, 0);
    @(negedge clk);
    eof_buffered = 1'b1;
    tick();
    chk("R5 start with eof", start_pulse, 1);
    end_frame();
    store_fwd = 1'b0;
  endtask

  task automatic t_short_frame();
    @(negedge clk);
    slow_mode = 1'b0; thr_code = 2'b11; fifo_level = 10'd3; eof_buffered = 1'b1;
    tick();
    chk("R6 short frame starts", start_pulse, 1);
    end_frame();
  endtask

  task automatic t_empty_idle();
    @(negedge clk);
    store_fwd = 1'b1; fifo_level = '0; eof_buffered = 1'b1;
    tick();
    tick();
    chk("R11 empty idle no start", start_pulse | drain_active, 0);
    @(negedge clk);
    store_fwd = 1'b0; eof_buffered = 1'b0;
  endtask

  task automatic t_hold_cfg();
    @(negedge clk);
    slow_mode = 1'b1; thr_code = 2'b01; fifo_level = 10'd24;
    tick();
    chk("R9 start", start_pulse, 1);
    @(negedge clk);
    thr_code = 2'b11; slow_mode = 1'b0; store_fwd = 1'b1; fifo_level = 10'd500;
    tick();
    tick();
    chk("R9 cur_thr held", cur_thr, 24);
    chk("R7 no restart", start_pulse, 0);
    store_fwd = 1'b0;
    end_frame();
  endtask

  task automatic t_underrun();
    chk("R10 clear before", underrun, 0);
    @(negedge clk);
    slow_mode = 1'b0; thr_code = 2'b00; fifo_level = 10'd32;
    tick();
    chk("R10 frame started", drain_active, 1);
    @(negedge clk);
    fifo_level = '0;
    tick();
    chk("R10 underrun set", underrun, 1);
    end_frame();
    @(negedge clk);
    fifo_level = 10'd40;
    tick();
    end_frame();
    chk("R10 underrun sticky", underrun, 1);
  endtask

  initial begin
    t_reset();
    scan_table(1'b0, 32, 64, 128, 256);
    scan_table(1'b1, 18, 24, 32, 40);
    t_store_fwd();
    t_short_frame();
    t_empty_idle();
    t_hold_cfg();
    t_underrun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule